// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin GPIO Port

This block is a general-purpose I/O port with 32 pins and a small word-addressed register interface. Each pin can drive a value from the data register when its output-enable bit is set, or act as an input. Every pad level is synchronised into the core clock domain, whatever the pin's direction. That synchronised level can be read back. It also feeds a per-pin trigger detector.

Each pin chooses a trigger from four codes: level low, level high, rising edge or falling edge. A separate per-pin bit selects triggering on both edges and overrides the code. A trigger sets a sticky status bit, and software clears that bit by writing 1 to it. A mask register gates status onto two request lines, one for each half of the port.

The register interface is a plain strobe bus. A write takes effect at the clock edge that samples `bus_wr`. A read strobe returns its data one cycle later, marked by `bus_rvalid`. The bus has no back-pressure: every strobe is accepted in the cycle it is presented.

Top module: `gpio_irq_port`

## Requirements
- R1: Register words are decoded from `bus_addr[5:2]`: 0 data, 1 output enable, 2 pad level (read-only), 3 trigger codes for pins 0–15, 4 trigger codes for pins 16–31, 5 mask, 6 status, 7 both-edge select. Writable registers read back the last value written. Any word above 7 reads as zero, and writes to it change nothing.
- R2: `pad_out` equals the data register and `pad_oe` equals the output-enable register, from the cycle after the write.
- R3: The pad-level word returns `pad_in` delayed by two clock edges, including for pins whose output enable is 1.
- R4: A pin's 2-bit trigger code sits at bits 2*(pin mod 16) of word 3 or word 4. Code 2 sets the pin's status bit on a 0-to-1 change of its synchronised level.
- R5: Code 3 sets the status bit on a 1-to-0 change and ignores 0-to-1 changes.
- R6: Code 0 (level low) and code 1 (level high) set the status bit in every cycle the level is present. A clearing write in such a cycle leaves the bit set.
- R7: When a pin's both-edge select bit is 1, its status bit is set on either change of level, and its trigger code has no effect.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Status bits stay set until they are cleared.
- R9: `irq_lo` is 1 exactly when status AND mask is non-zero over pins 0–15, and `irq_hi` likewise over pins 16–31. A masked pin still records status.
- R10: After reset, the data, output-enable, trigger-code, mask, status and both-edge registers are zero, and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address; bits 5:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | High for one cycle, the cycle after a read strobe |
| pad_in | input | 32 | Raw pad levels (asynchronous) |
| pad_out | output | 32 | Values to drive onto the pads |
| pad_oe | output | 32 | Per-pin drive enable |
| irq_lo | output | 1 | Request for pins 0–15 |
| irq_hi | output | 1 | Request for pins 16–31 |

## Verification
Register and pad outputs move one edge after a write. A read answers one edge after its strobe. A pad change is seen in the pad-level word two edges later, and in status and the request lines three edges later. The bench drives on falling edges and samples on falling edges. After each pad change it waits at least four cycles before issuing a read. A scoreboard queue holds the expected read data, and a monitor pops it when `bus_rvalid` rises. Request and pad outputs are checked directly on the falling edge after the write that should move them.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // word indices inside the register window
  localparam int unsigned WORD_DATA  = 0;
  localparam int unsigned WORD_OE    = 1;
  localparam int unsigned WORD_LEVEL = 2;
  localparam int unsigned WORD_CLO   = 3;
  localparam int unsigned WORD_CHI   = 4;
  localparam int unsigned WORD_MASK  = 5;
  localparam int unsigned WORD_STAT  = 6;
  localparam int unsigned WORD_BOTH  = 7;
  localparam int unsigned WORD_LAST  = 7;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, cur_q, prev_q;
  logic [1:0]   age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
      age_q  <= '0;
    end else begin
      meta_q <= raw;
      cur_q  <= meta_q;
      prev_q <= cur_q;
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (cur == $past(raw, 2)));  // R3
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   cur,
  input  logic [NPINS-1:0]   prev,
  input  logic [2*NPINS-1:0] codes,
  input  logic [NPINS-1:0]   both_sel,
  output logic [NPINS-1:0]   hit
);
  logic [NPINS-1:0] changed;
  assign changed = cur ^ prev;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    trig_e code;
    assign code = trig_e'(codes[2*p +: 2]);
    always_comb begin
      if (both_sel[p]) begin
        hit[p] = changed[p];
      end else begin
        unique case (code)
          TRIG_LOW:  hit[p] = ~cur[p];
          TRIG_HIGH: hit[p] = cur[p];
          TRIG_RISE: hit[p] = cur[p] & ~prev[p];
          TRIG_FALL: hit[p] = ~cur[p] & prev[p];
        endcase
      end
    end
  end

  AST_BOTH_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & both_sel & ~changed) == '0));  // R7
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic             bus_rvalid,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq_lo,
  output logic             irq_hi
);
  localparam int HALF = NPINS / 2;
  localparam int WW   = AW - 2;

  logic [NPINS-1:0] data_q, oe_q, mask_q, stat_q, both_q;
  logic [NPINS-1:0] clo_q, chi_q;
  logic [NPINS-1:0] lvl_cur, lvl_prev, hit, pending;
  logic [NPINS-1:0] rd_mux, rdata_q;
  logic             rvalid_q;
  logic [WW-1:0]    word;
  logic             in_window;
  logic             wr_data, wr_oe, wr_clo, wr_chi, wr_mask, wr_stat, wr_both;

  assign word      = bus_addr[AW-1:2];
  assign in_window = (word <= WW'(WORD_LAST));
  assign wr_data   = bus_wr && (word == WW'(WORD_DATA));
  assign wr_oe     = bus_wr && (word == WW'(WORD_OE));
  assign wr_clo    = bus_wr && (word == WW'(WORD_CLO));
  assign wr_chi    = bus_wr && (word == WW'(WORD_CHI));
  assign wr_mask   = bus_wr && (word == WW'(WORD_MASK));
  assign wr_stat   = bus_wr && (word == WW'(WORD_STAT));
  assign wr_both   = bus_wr && (word == WW'(WORD_BOTH));

  gpio_pad_sync #(.W(NPINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (pad_in),
    .cur  (lvl_cur),
    .prev (lvl_prev)
  );

  gpio_trig_detect #(.NPINS(NPINS)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .cur     (lvl_cur),
    .prev    (lvl_prev),
    .codes   ({chi_q, clo_q}),
    .both_sel(both_q),
    .hit     (hit)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      oe_q   <= '0;
      clo_q  <= '0;
      chi_q  <= '0;
      mask_q <= '0;
      both_q <= '0;
    end else begin
      if (wr_data) data_q <= bus_wdata;
      if (wr_oe)   oe_q   <= bus_wdata;
      if (wr_clo)  clo_q  <= bus_wdata;
      if (wr_chi)  chi_q  <= bus_wdata;
      if (wr_mask) mask_q <= bus_wdata;
      if (wr_both) both_q <= bus_wdata;
    end
  end

  // sticky status: new triggers win over a clearing write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (wr_stat) begin
      stat_q <= (stat_q & ~bus_wdata) | hit;
    end else begin
      stat_q <= stat_q | hit;
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    if (in_window) begin
      unique case (word)
        WW'(WORD_DATA):  rd_mux = data_q;
        WW'(WORD_OE):    rd_mux = oe_q;
        WW'(WORD_LEVEL): rd_mux = lvl_cur;
        WW'(WORD_CLO):   rd_mux = clo_q;
        WW'(WORD_CHI):   rd_mux = chi_q;
        WW'(WORD_MASK):  rd_mux = mask_q;
        WW'(WORD_STAT):  rd_mux = stat_q;
        default:         rd_mux = both_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign pad_out    = data_q;
  assign pad_oe     = oe_q;
  assign pending    = stat_q & mask_q;
  assign irq_lo     = |pending[HALF-1:0];
  assign irq_hi     = |pending[NPINS-1:HALF];

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));  // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !in_window) |=> (bus_rdata == '0));  // R1
  AST_PAD_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (pad_out == $past(bus_wdata)));  // R2
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);  // R1
  AST_HIT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((stat_q & $past(hit)) == $past(hit)));  // R6
endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, pad_in = '0, pad_out, pad_oe;
  logic        bus_rvalid, irq_lo, irq_hi;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) check("R1 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pads(logic [31:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (4) @(negedge clk);
  endtask

  localparam logic [5:0] A_DATA = 6'h00, A_OE = 6'h04, A_LVL = 6'h08,
    A_CLO = 6'h0C, A_CHI = 6'h10, A_MASK = 6'h14, A_STAT = 6'h18,
    A_BOTH = 6'h1C, A_NONE = 6'h24;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 pad_out", pad_out, 0);
    check("R10 pad_oe", pad_oe, 0);
    check("R10 irq", {30'd0, irq_hi, irq_lo}, 0);
    rd(A_MASK, 0, "R10 mask");
    rd(A_DATA, 0, "R10 data");
    rd(A_BOTH, 0, "R10 both");
    rd(A_CLO, 0, "R10 codes");
    rd(A_STAT, 32'hFFFF_FFFF, "R6 level-low default sets all");
    wr(A_CLO, 32'hAAAA_AAAA);
    wr(A_CHI, 32'hAAAA_AAAA);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 0, "R8 clear all");
    rd(A_CHI, 32'hAAAA_AAAA, "R1 readback");
    wr(A_NONE, 32'hDEAD_BEEF);
    rd(A_NONE, 0, "R1 unmapped");
    rd(A_BOTH, 0, "R1 unmapped write no alias");
    wr(A_DATA, 32'h1234_5678);
    wr(A_OE, 32'h0000_FFFF);
    check("R2 pad_out", pad_out, 32'h1234_5678);
    check("R2 pad_oe", pad_oe, 32'h0000_FFFF);
    rd(A_DATA, 32'h1234_5678, "R1 data readback");
    pads(32'h0F0F_0001);
    rd(A_LVL, 32'h0F0F_0001, "R3 pad level incl output pin 0");
    rd(A_STAT, 32'h0F0F_0001, "R4 rising sets status");
    check("R9 masked no irq", {30'd0, irq_hi, irq_lo}, 0);
    wr(A_MASK, 32'h0001_0000);
    check("R9 irq_hi", {30'd0, irq_hi, irq_lo}, 32'd2);
    rd(A_MASK, 32'h0001_0000, "R1 mask readback");
    wr(A_STAT, 32'h0000_0001);
    check("R9 irq_hi unaffected", {30'd0, irq_hi, irq_lo}, 32'd2);
    wr(A_STAT, 32'h0001_0000);
    check("R8 w1c drops irq_hi", {30'd0, irq_hi, irq_lo}, 0);
    wr(A_STAT, 32'h0000_0000);
    rd(A_STAT, 32'h0F0E_0000, "R8 zero write keeps");
    wr(A_STAT, 32'hFFFF_FFFF);
    // R5: pin 2 falling
    wr(A_CLO, 32'hAAAA_AABA);
    pads(32'h0F0F_0005);
    rd(A_STAT, 0, "R5 rise ignored");
    pads(32'h0F0F_0001);
    rd(A_STAT, 32'h0000_0004, "R5 fall sets");
    wr(A_STAT, 32'hFFFF_FFFF);
    // R7: pin 3 both edges, code level-low ignored
    wr(A_BOTH, 32'h0000_0008);
    wr(A_CLO, 32'hAAAA_AA3A);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 0, "R7 code ignored");
    pads(32'h0F0F_0009);
    rd(A_STAT, 32'h0000_0008, "R7 rise");
    wr(A_STAT, 32'hFFFF_FFFF);
    pads(32'h0F0F_0001);
    rd(A_STAT, 32'h0000_0008, "R7 fall");
    wr(A_STAT, 32'hFFFF_FFFF);
    // R6: pin 5 level high
    wr(A_CLO, 32'hAAAA_A63A);
    rd(A_STAT, 0, "R6 inactive level");
    pads(32'h0F0F_0021);
    wr(A_STAT, 32'h0000_0020);
    rd(A_STAT, 32'h0000_0020, "R6 set wins over clear");
    wr(A_MASK, 32'h0000_0020);
    check("R9 irq_lo", {30'd0, irq_hi, irq_lo}, 32'd1);
    pads(32'h0F0F_0001);
    wr(A_STAT, 32'h0000_0020);
    rd(A_STAT, 0, "R6 cleared after level gone");
    check("R9 irq_lo off", {30'd0, irq_hi, irq_lo}, 0);
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R1 reads outstanding", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      done = 1;
      check("watchdog", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule